// File: doc/BRIEF.md
# Descriptor Ring Queue Engine

This block manages the two memory rings of a command DMA channel. Software places fixed-size request descriptors of eight 32-bit words in a request ring, then moves the request-in index forward. While the channel is running, the engine takes the entry at request-out. It issues a fetch for the entry and accepts the eight descriptor words. Then it advances request-out and writes a one-word response record into the response ring at response-in. After that it advances response-in and raises the channel's completion cause bit. Software drains responses by stepping response-out until it equals response-in.

Both rings hold 2^IDX_W entries (32 by default), and every index wraps modulo that size. The descriptor fetch, the descriptor word stream and the response post are valid/ready interfaces. A source that raises valid keeps valid and its payload unchanged until ready is seen at a clock edge. The only exception is a channel reset, which abandons the transfer in flight. The sink may hold off with ready low for any number of cycles. The register port, the command bits and the interrupt are plain signals. Register reads are combinational from `reg_addr`. A write takes effect at the clock edge where `reg_wr_en` is high.

Top module: `dring_qeng`

## Requirements
- R1: After `rst_n` is released, every register reads 0, `irq` is 0, and `fetch_valid` and `post_valid` are 0.
- R2: Register addresses are 0 command, 1 request-in, 2 request-out, 3 response-in, 4 response-out and 5 cause. The request base is bits [31:10] of request-in (1 KiB aligned) and the request index is bits [9:5]. The response base is bits [31:8] of response-out (256-byte aligned) and the response index is bits [7:3]. The request-out and response-in registers read the matching base together with their own index, and writes to them are ignored. Bits below each index field read 0.
- R3: A new fetch starts only when all of these hold: the channel is running, it is not frozen and no stop is pending, request-out differs from request-in, and the response ring is not full. The ring is full when response-in plus one equals response-out modulo 32.
- R4: The fetch address is the request base plus 32 times request-out. The engine accepts exactly eight descriptor words. Request-out advances by one, wrapping modulo 32, when the eighth word is taken.
- R5: The response is posted at the response base plus 8 times response-in. Its data is descriptor word 2 ANDed with 0x0001F03F, which keeps the direction bit 0, the tag bits [5:1], the port bits [15:12] and the table-mode flag bit 16. Response-in advances by one, wrapping, when the post is accepted.
- R6: Acceptance of a post sets cause bit PORT_SEL. `irq` is the OR of the cause bits. A write to the cause register clears each bit written 0 and leaves each bit written 1 unchanged.
- R7: Writing 1 to command bit 0 starts a stopped channel, and command bit 0 reads 1 while the channel runs. Writing 1 to bit 1 requests a stop, and bit 1 always reads 0. The request in progress is completed, and then bit 0 drops to 0.
- R8: A single command write with both bit 0 and bit 1 set does not start a stopped channel.
- R9: Command bit 4 is stored on every command write and reads back at bit 4. While it is 1, no new fetch starts, but the channel stays running.
- R10: Writing 1 to command bit 2 stops the channel at the next edge and abandons any transfer in progress. It also clears all four indices and the freeze bit. The base addresses are kept.
- R11: `fetch_valid` and `post_valid`, together with their payloads, stay stable until accepted. The only exception is a channel reset. At most one of `fetch_valid`, `desc_ready` and `post_valid` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| fetch_valid | output | 1 | Descriptor fetch request valid |
| fetch_ready | input | 1 | Descriptor fetch request accepted |
| fetch_addr | output | 32 | Byte address of the descriptor entry |
| desc_valid | input | 1 | Descriptor word valid |
| desc_ready | output | 1 | Engine takes descriptor words |
| desc_data | input | 32 | Descriptor word, first word first |
| post_valid | output | 1 | Response post valid |
| post_ready | input | 1 | Response post accepted |
| post_addr | output | 32 | Byte address of the response entry |
| post_data | output | 32 | Response record |
| irq | output | 1 | OR of the completion cause bits |

## Verification
The checks assume that the memory side keeps `desc_valid` and its word steady until they are taken. They also assume that descriptor words arrive only after the fetch that asked for them. The bench model raises words only after a fetch handshake and holds any word that has not been taken. It also assumes at most one register write per cycle, which the bench's write task guarantees. Ready and valid gaps follow fixed cycle patterns, so back-pressure lands on every phase. One post is held off on purpose to place a stop request and a channel reset in the middle of a transfer.

// File: rtl/dring_pkg.sv
package dring_pkg;
  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_RECV,
    S_POST
  } seq_state_e;

  localparam int CMD_EN_BIT  = 0;
  localparam int CMD_DIS_BIT = 1;
  localparam int CMD_RST_BIT = 2;
  localparam int CMD_FRZ_BIT = 4;

  localparam logic [2:0] RA_CMD   = 3'd0;
  localparam logic [2:0] RA_RQIN  = 3'd1;
  localparam logic [2:0] RA_RQOUT = 3'd2;
  localparam logic [2:0] RA_RSIN  = 3'd3;
  localparam logic [2:0] RA_RSOUT = 3'd4;
  localparam logic [2:0] RA_CAUSE = 3'd5;

  localparam int          CTL_WORD      = 2;
  localparam logic [31:0] CTL_KEEP_MASK = 32'h0001_F03F;
endpackage

// File: rtl/dring_ptr.sv
module dring_ptr #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld,
  input  logic [IDX_W-1:0] ld_val,
  input  logic             inc,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (clr)  idx <= '0;
    else if (ld)   idx <= ld_val;
    else if (inc)  idx <= idx + IDX_W'(1);
  end
endmodule

// File: rtl/dring_ctl.sv
module dring_ctl
  import dring_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              seq_idle,
  output logic              running,
  output logic              freeze,
  output logic              stop_pend,
  output logic              chan_rst
);
  assign chan_rst = cmd_wr && cmd_data[CMD_RST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      freeze    <= 1'b0;
      stop_pend <= 1'b0;
    end else if (chan_rst) begin
      running   <= 1'b0;
      freeze    <= 1'b0;
      stop_pend <= 1'b0;
    end else begin
      if (cmd_wr) freeze <= cmd_data[CMD_FRZ_BIT];
      if (cmd_wr && cmd_data[CMD_DIS_BIT]) begin
        if (running) stop_pend <= 1'b1;
      end else if (cmd_wr && cmd_data[CMD_EN_BIT] && !running) begin
        running <= 1'b1;
      end
      if (stop_pend && seq_idle) begin
        running   <= 1'b0;
        stop_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dring_seq.sv
module dring_seq
  import dring_pkg::*;
#(
  parameter int IDX_W     = 5,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int REQ_WORDS = 8,
  parameter int REQ_SHIFT = 5,
  parameter int RS_SHIFT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              go,
  input  logic [IDX_W-1:0]  rq_in,
  input  logic [IDX_W-1:0]  rq_out,
  input  logic [IDX_W-1:0]  rs_in,
  input  logic [IDX_W-1:0]  rs_out,
  input  logic [ADDR_W-1:0] rq_base,
  input  logic [ADDR_W-1:0] rs_base,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [DATA_W-1:0] desc_data,
  output logic              post_valid,
  input  logic              post_ready,
  output logic [ADDR_W-1:0] post_addr,
  output logic [DATA_W-1:0] post_data,
  output logic              rq_inc,
  output logic              rs_inc,
  output logic              idle
);
  localparam int WC_W = (REQ_WORDS > 1) ? $clog2(REQ_WORDS) : 1;

  seq_state_e        state;
  logic [WC_W-1:0]   wcnt;
  logic [DATA_W-1:0] ctl_q;
  logic              req_avail;
  logic              rs_room;
  logic              last_word;

  assign rs_room    = (rs_in + IDX_W'(1)) != rs_out;
  assign req_avail  = (rq_out != rq_in) && rs_room;
  assign last_word  = wcnt == WC_W'(REQ_WORDS - 1);

  assign fetch_valid = state == S_FETCH;
  assign desc_ready  = state == S_RECV;
  assign post_valid  = state == S_POST;
  assign idle        = state == S_IDLE;
  assign rq_inc      = (state == S_RECV) && desc_valid && last_word;
  assign rs_inc      = (state == S_POST) && post_ready;
  assign post_data   = ctl_q & DATA_W'(CTL_KEEP_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      wcnt       <= '0;
      ctl_q      <= '0;
      fetch_addr <= '0;
      post_addr  <= '0;
    end else if (abort) begin
      state <= S_IDLE;
      wcnt  <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (go && req_avail) begin
            fetch_addr <= rq_base | (ADDR_W'(rq_out) << REQ_SHIFT);
            state      <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (fetch_ready) begin
            wcnt  <= '0;
            state <= S_RECV;
          end
        end
        S_RECV: begin
          if (desc_valid) begin
            if (wcnt == WC_W'(CTL_WORD)) ctl_q <= desc_data;
            if (last_word) begin
              post_addr <= rs_base | (ADDR_W'(rs_in) << RS_SHIFT);
              state     <= S_POST;
            end else begin
              wcnt <= wcnt + WC_W'(1);
            end
          end
        end
        S_POST: begin
          if (post_ready) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dring_qeng.sv
module dring_qeng
  import dring_pkg::*;
#(
  parameter int IDX_W     = 5,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int REQ_WORDS = 8,
  parameter int RSP_BYTES = 8,
  parameter int NPORT     = 2,
  parameter int PORT_SEL  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [DATA_W-1:0] desc_data,
  output logic              post_valid,
  input  logic              post_ready,
  output logic [ADDR_W-1:0] post_addr,
  output logic [DATA_W-1:0] post_data,
  output logic              irq
);
  localparam int REQ_BYTES   = REQ_WORDS * (DATA_W / 8);
  localparam int REQ_SHIFT   = $clog2(REQ_BYTES);
  localparam int RS_SHIFT    = $clog2(RSP_BYTES);
  localparam int RQ_BASE_LSB = REQ_SHIFT + IDX_W;
  localparam int RS_BASE_LSB = RS_SHIFT + IDX_W;

  logic cmd_wr, rqin_wr, rsout_wr, cause_wr;
  assign cmd_wr   = reg_wr_en && (reg_addr == RA_CMD);
  assign rqin_wr  = reg_wr_en && (reg_addr == RA_RQIN);
  assign rsout_wr = reg_wr_en && (reg_addr == RA_RSOUT);
  assign cause_wr = reg_wr_en && (reg_addr == RA_CAUSE);

  logic [ADDR_W-1:RQ_BASE_LSB] rq_base_q;
  logic [ADDR_W-1:RS_BASE_LSB] rs_base_q;
  logic [ADDR_W-1:0]           rq_base_full, rs_base_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_base_q <= '0;
      rs_base_q <= '0;
    end else begin
      if (rqin_wr)  rq_base_q <= reg_wdata[ADDR_W-1:RQ_BASE_LSB];
      if (rsout_wr) rs_base_q <= reg_wdata[ADDR_W-1:RS_BASE_LSB];
    end
  end
  assign rq_base_full = {rq_base_q, {RQ_BASE_LSB{1'b0}}};
  assign rs_base_full = {rs_base_q, {RS_BASE_LSB{1'b0}}};

  logic             run_w, freeze_w, stop_w, chan_rst, seq_idle;
  logic             rq_inc, rs_inc;
  logic [IDX_W-1:0] rq_in_w, rq_out_w, rs_in_w, rs_out_w;

  dring_ptr #(.IDX_W(IDX_W)) u_rq_in (
    .clk(clk), .rst_n(rst_n), .clr(chan_rst), .ld(rqin_wr),
    .ld_val(reg_wdata[REQ_SHIFT +: IDX_W]), .inc(1'b0), .idx(rq_in_w)
  );
  dring_ptr #(.IDX_W(IDX_W)) u_rq_out (
    .clk(clk), .rst_n(rst_n), .clr(chan_rst), .ld(1'b0),
    .ld_val('0), .inc(rq_inc), .idx(rq_out_w)
  );
  dring_ptr #(.IDX_W(IDX_W)) u_rs_in (
    .clk(clk), .rst_n(rst_n), .clr(chan_rst), .ld(1'b0),
    .ld_val('0), .inc(rs_inc), .idx(rs_in_w)
  );
  dring_ptr #(.IDX_W(IDX_W)) u_rs_out (
    .clk(clk), .rst_n(rst_n), .clr(chan_rst), .ld(rsout_wr),
    .ld_val(reg_wdata[RS_SHIFT +: IDX_W]), .inc(1'b0), .idx(rs_out_w)
  );

  dring_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(reg_wdata),
    .seq_idle(seq_idle), .running(run_w), .freeze(freeze_w),
    .stop_pend(stop_w), .chan_rst(chan_rst)
  );

  dring_seq #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REQ_WORDS(REQ_WORDS),
    .REQ_SHIFT(REQ_SHIFT), .RS_SHIFT(RS_SHIFT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .abort(chan_rst),
    .go(run_w && !freeze_w && !stop_w),
    .rq_in(rq_in_w), .rq_out(rq_out_w), .rs_in(rs_in_w), .rs_out(rs_out_w),
    .rq_base(rq_base_full), .rs_base(rs_base_full),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
    .post_valid(post_valid), .post_ready(post_ready), .post_addr(post_addr),
    .post_data(post_data), .rq_inc(rq_inc), .rs_inc(rs_inc), .idle(seq_idle)
  );

  logic [NPORT-1:0] cause_q;
  for (genvar p = 0; p < NPORT; p++) begin : g_cause
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            bit_q <= 1'b0;
      else if ((p == PORT_SEL) && rs_inc)    bit_q <= 1'b1;
      else if (cause_wr && !reg_wdata[p])    bit_q <= 1'b0;
    end
    assign cause_q[p] = bit_q;
  end
  assign irq = |cause_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CMD: begin
        reg_rdata[CMD_EN_BIT]  = run_w;
        reg_rdata[CMD_FRZ_BIT] = freeze_w;
      end
      RA_RQIN:  reg_rdata = DATA_W'(rq_base_full) | (DATA_W'(rq_in_w)  << REQ_SHIFT);
      RA_RQOUT: reg_rdata = DATA_W'(rq_base_full) | (DATA_W'(rq_out_w) << REQ_SHIFT);
      RA_RSIN:  reg_rdata = DATA_W'(rs_base_full) | (DATA_W'(rs_in_w)  << RS_SHIFT);
      RA_RSOUT: reg_rdata = DATA_W'(rs_base_full) | (DATA_W'(rs_out_w) << RS_SHIFT);
      RA_CAUSE: reg_rdata[NPORT-1:0] = cause_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dring_qeng_chk.sv
module dring_qeng_chk
  import dring_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [2:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              desc_ready,
  input logic              post_valid,
  input logic              post_ready,
  input logic [ADDR_W-1:0] post_addr,
  input logic [DATA_W-1:0] post_data,
  input logic              irq,
  input logic              run_w,
  input logic [IDX_W-1:0]  rq_out_w
);
  logic rst_cmd;
  assign rst_cmd = reg_wr_en && (reg_addr == RA_CMD) && reg_wdata[CMD_RST_BIT];

  // R11
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !rst_cmd) |=> (fetch_valid && $stable(fetch_addr)));

  // R11
  post_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && !post_ready && !rst_cmd) |=>
      (post_valid && $stable(post_addr) && $stable(post_data)));

  // R11
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_valid, desc_ready, post_valid}));

  // R6
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && post_ready) |=> irq);

  // R3
  fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_valid) |-> $past(run_w));

  // R4
  rqout_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_out_w != $past(rq_out_w)) |->
      ((rq_out_w == $past(rq_out_w) + IDX_W'(1)) || (rq_out_w == '0)));

  // R10
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> (rq_out_w == '0 && !run_w && !fetch_valid && !post_valid));
endmodule

bind dring_qeng dring_qeng_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
  .fetch_addr(fetch_addr), .desc_ready(desc_ready), .post_valid(post_valid),
  .post_ready(post_ready), .post_addr(post_addr), .post_data(post_data),
  .irq(irq), .run_w(run_w), .rq_out_w(rq_out_w)
);

// File: tb/dring_qeng_tb.sv
module dring_qeng_tb;
  localparam logic [31:0] RQB = 32'h0001_0400;
  localparam logic [31:0] RSB = 32'h0002_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fetch_valid, fetch_ready;
  logic [31:0] fetch_addr;
  logic        desc_valid, desc_ready;
  logic [31:0] desc_data;
  logic        post_valid, post_ready;
  logic [31:0] post_addr, post_data;
  logic        irq;

  int total = 0, bad = 0;
  int cyc = 0, n_fetch = 0, n_post = 0;
  int exp_rq = 0, exp_rs = 0, words_left = 0, widx = 0;
  bit dv_pend = 0, post_hold = 0, done = 0;
  logic [31:0] cur_ctl = '0, cur_addr = '0, rv;

  dring_qeng u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_addr(fetch_addr), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_data(desc_data), .post_valid(post_valid),
    .post_ready(post_ready), .post_addr(post_addr), .post_data(post_data), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  function automatic logic [31:0] gen_ctl(input int i);
    logic [4:0] ix;
    ix = 5'(i);
    return {15'h2B3C, ix[0], ix[3:0] ^ 4'h9, 6'h3F, ix, ix[1] ^ ix[4]};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // memory model: fetch, descriptor words, post
  initial begin
    fetch_ready = 1'b0; desc_valid = 1'b0; desc_data = '0; post_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      fetch_ready = (cyc % 3 != 1);
      if (fetch_valid && fetch_ready) begin
        chk("R4 fetch address", fetch_addr, RQB + 32'(exp_rq * 32));
        cur_addr = fetch_addr;
        cur_ctl = gen_ctl(exp_rq);
        exp_rq = (exp_rq + 1) % 32;
        words_left = 8; widx = 0; n_fetch++;
      end
      if (!dv_pend) desc_valid = (words_left > 0) && (cyc % 4 != 3);
      desc_data = (widx == 2) ? cur_ctl : {cur_addr[15:0], 8'(widx), 8'hA5};
      if (desc_valid && desc_ready) begin
        widx++; words_left--; dv_pend = 0;
      end else begin
        dv_pend = desc_valid;
      end
      post_ready = !post_hold && (cyc % 2 == 0);
      if (post_valid && post_ready) begin
        chk("R5 post address", post_addr, RSB + 32'(exp_rs * 8));
        chk("R5 post data", post_data, cur_ctl & 32'h0001_F03F);
        exp_rs = (exp_rs + 1) % 32;
        n_post++;
      end
    end
  end

  initial begin
    waitc(100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    waitc(3);
    rst_n = 1'b1;
    waitc(2);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), rv); chk("R1 register reset value", rv, 32'h0);
    end
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 fetch_valid after reset", 32'(fetch_valid), 0);

    // R2 layout and masking
    wr(3'd1, 32'h0001_041F);
    rd(3'd1, rv); chk("R2 request-in readback", rv, RQB);
    rd(3'd2, rv); chk("R2 request-out readback", rv, RQB);
    wr(3'd4, 32'h0002_0107);
    rd(3'd4, rv); chk("R2 response-out readback", rv, RSB);
    rd(3'd3, rv); chk("R2 response-in readback", rv, RSB);
    wr(3'd2, 32'h0000_03E0);
    rd(3'd2, rv); chk("R2 request-out write ignored", rv, RQB);

    // R3 nothing while stopped
    wr(3'd1, RQB | (3 << 5));
    waitc(30);
    chk("R3 no fetch while stopped", n_fetch, 0);
    rd(3'd2, rv); chk("R3 request-out while stopped", rv, RQB);

    // R7 start and process three
    wr(3'd0, 32'h1);
    waitc(200);
    chk("R7 three posts", n_post, 3);
    rd(3'd2, rv); chk("R4 request-out after three", rv, RQB | (3 << 5));
    rd(3'd3, rv); chk("R5 response-in after three", rv, RSB | (3 << 3));
    rd(3'd0, rv); chk("R7 running readback", rv, 32'h1);
    chk("R6 irq set", 32'(irq), 1);
    rd(3'd5, rv); chk("R6 cause bit", rv, 32'h1);

    // R6 write-zero-to-clear
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, rv); chk("R6 cause kept by ones", rv, 32'h1);
    wr(3'd5, 32'hFFFF_FFFE);
    rd(3'd5, rv); chk("R6 cause cleared by zero", rv, 32'h0);
    chk("R6 irq cleared", 32'(irq), 0);

    // R3 response ring full stops acceptance
    wr(3'd1, RQB | (2 << 5));
    waitc(1500);
    chk("R3 posts until full", n_post, 31);
    rd(3'd2, rv); chk("R3 request-out at full", rv, RQB | (31 << 5));
    rd(3'd3, rv); chk("R3 response-in at full", rv, RSB | (31 << 3));
    waitc(50);
    chk("R3 no post while full", n_post, 31);
    chk("R3 no fetch while full", 32'(fetch_valid), 0);
    wr(3'd4, RSB | (31 << 3));
    waitc(300);
    chk("R4 posts after drain", n_post, 34);
    rd(3'd2, rv); chk("R4 request-out wrapped", rv, RQB | (2 << 5));
    rd(3'd3, rv); chk("R5 response-in wrapped", rv, RSB | (2 << 3));

    // R9 freeze
    wr(3'd0, 32'h11);
    wr(3'd1, RQB | (5 << 5));
    waitc(60);
    chk("R9 no post while frozen", n_post, 34);
    rd(3'd0, rv); chk("R9 freeze readback", rv, 32'h11);
    wr(3'd0, 32'h01);
    waitc(200);
    chk("R9 resume after freeze", n_post, 37);
    rd(3'd2, rv); chk("R9 request-out after resume", rv, RQB | (5 << 5));

    // R7 disable completes current request
    post_hold = 1;
    wr(3'd1, RQB | (7 << 5));
    waitc(40);
    chk("R7 post pending", 32'(post_valid), 1);
    wr(3'd0, 32'h02);
    waitc(3);
    rd(3'd0, rv); chk("R7 still running, disable self-clears", rv, 32'h1);
    post_hold = 0;
    waitc(60);
    chk("R7 in-flight request completed", n_post, 38);
    rd(3'd0, rv); chk("R7 stopped readback", rv, 32'h0);
    rd(3'd2, rv); chk("R7 request-out after stop", rv, RQB | (6 << 5));
    wr(3'd0, 32'h01);
    waitc(60);
    chk("R7 restart finishes last", n_post, 39);
    rd(3'd2, rv); chk("R7 request-out after restart", rv, RQB | (7 << 5));

    // R10 channel reset
    post_hold = 1;
    wr(3'd0, 32'h11);
    wr(3'd0, 32'h01);
    wr(3'd1, RQB | (10 << 5));
    waitc(40);
    chk("R10 post pending before reset", 32'(post_valid), 1);
    wr(3'd0, 32'h14);
    exp_rq = 0; exp_rs = 0; words_left = 0; dv_pend = 0;
    waitc(2);
    chk("R10 post dropped", 32'(post_valid), 0);
    chk("R10 fetch idle", 32'(fetch_valid), 0);
    rd(3'd0, rv); chk("R10 command cleared", rv, 32'h0);
    rd(3'd1, rv); chk("R10 request-in cleared", rv, RQB);
    rd(3'd2, rv); chk("R10 request-out cleared", rv, RQB);
    rd(3'd3, rv); chk("R10 response-in cleared", rv, RSB);
    rd(3'd4, rv); chk("R10 response-out cleared", rv, RSB);
    post_hold = 0;
    waitc(20);
    chk("R10 no post after reset", n_post, 39);

    wr(3'd0, 32'h01);
    wr(3'd1, RQB | (4 << 5));
    waitc(150);
    chk("R10 posts after reset", n_post, 43);
    rd(3'd2, rv); chk("R10 request-out from zero", rv, RQB | (4 << 5));
    rd(3'd3, rv); chk("R10 response-in from zero", rv, RSB | (4 << 3));

    // R8 enable with disable in one write
    wr(3'd0, 32'h02);
    waitc(5);
    rd(3'd0, rv); chk("R7 idle disable stops", rv, 32'h0);
    wr(3'd0, 32'h03);
    waitc(5);
    rd(3'd0, rv); chk("R8 both bits stay stopped", rv, 32'h0);
    wr(3'd1, RQB | (6 << 5));
    waitc(60);
    chk("R8 no work after both bits", n_post, 43);
    rd(3'd2, rv); chk("R8 request-out unchanged", rv, RQB | (4 << 5));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule